// File: doc/BRIEF.md
# Write-Protection and Status Register Unit

This unit sits beside the command decoder of a serial nonvolatile byte memory with 8192 locations. It holds the volatile write-enable latch and the three persistent protection fields of the 8-bit status byte. From these fields it works out, every cycle, whether a status-register update is allowed and whether a memory write to the candidate address is allowed. The decoder turns serial traffic into one-cycle event pulses and presents them to this unit. The four events are enable, disable, status-byte load and end-of-write (chip select rising after any write). The unit itself never decodes the serial stream.

Protection works in three layers. The enable latch must be open before any write. Two block-protect bits fence off the top quarter of the array, the top half, or the whole of it. A lock flag makes the active-low hardware protect pin freeze the status register; when the flag is clear the pin is ignored. The pin never gates array writes directly.

The latch is a two-state machine with states EN_CLOSED and EN_OPEN. The transition OPEN_ON_SET goes from EN_CLOSED to EN_OPEN on an enable pulse when no disable or end-of-write pulse is present. The transition CLOSE_ON_CLEAR goes from EN_OPEN to EN_CLOSED on a disable or end-of-write pulse. In every other case each state holds. The persistent fields are plain registers that load a parameterized value at reset, standing in for real retention.

Top module: `wp_status_unit`

## Requirements
- R1: `status_byte` carries the lock flag in bit 7, block-protect high in bit 3, block-protect low in bit 2 and the latch in bit 1. Bits 6, 5, 4 and 0 always read 0.
- R2: The latch reads 0 after reset. An enable pulse opens it at the next clock edge. A disable pulse or an end-of-write pulse closes it at the next clock edge. When an enable pulse and a closing pulse arrive in the same cycle, the latch closes.
- R3: A status-byte load that is permitted copies data bits 7, 3 and 2 into the lock flag and the two block-protect bits at the next edge. It leaves the latch unchanged, and the fixed-zero bits stay 0. A load that is not permitted changes nothing.
- R4: Block-protect code 00 protects no address. Code 01 protects 1800h to 1FFFh, code 10 protects 1000h to 1FFFh, and code 11 protects 0000h to 1FFFh. The code is bit 3 followed by bit 2.
- R5: `mem_wr_permit` is 1 exactly when the latch is open and `cand_addr` lies outside the protected range.
- R6: `sr_wr_permit` is 1 exactly when the latch is open and it is not the case that the lock flag is 1 while `hw_wp_n` is 0. With the lock flag at 0 the pin has no effect.
- R7: `hw_wp_n` never changes `mem_wr_permit`.
- R8: At reset the lock flag and block-protect bits take parameter `RST_PROT`, which is {lock, bp1, bp0} and defaults to 000.
- R9: Both permits are combinational from the present register state, the pin and the address. A status load therefore affects the permits from the cycle after its clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_set_en | input | 1 | Enable-command pulse |
| cmd_clr_en | input | 1 | Disable-command pulse |
| sr_wr_valid | input | 1 | Status-byte load request |
| sr_wr_data | input | 8 | Status byte to load |
| wr_done | input | 1 | End of a write operation (chip select rising) |
| hw_wp_n | input | 1 | Hardware protect pin, active low |
| cand_addr | input | 13 | Address of the candidate array write |
| status_byte | output | 8 | Status byte for reads |
| sr_wr_permit | output | 1 | Status-register update allowed |
| mem_wr_permit | output | 1 | Array write to `cand_addr` allowed |

## Verification
Event pulses take effect at the clock edge that samples them. `status_byte` shows the new value one nanosecond after that edge. The permits change with the pin and the address in the same cycle, and they reflect a status load from the following cycle. The bench drives stimulus on the falling edge and compares all three outputs one nanosecond later against a behavioural model. The model is advanced only after the rising edge, so every comparison uses the state that held before the edge.

// File: rtl/wp_status_pkg.sv
package wp_status_pkg;

    localparam int SR_W     = 8;
    localparam int BIT_LOCK = 7;
    localparam int BIT_BPH  = 3;
    localparam int BIT_BPL  = 2;
    localparam int BIT_LAT  = 1;

    typedef enum logic {
        EN_CLOSED = 1'b0,
        EN_OPEN   = 1'b1
    } en_state_e;

    typedef struct packed {
        logic       lock;
        logic [1:0] blk;
    } prot_t;

    function automatic logic [SR_W-1:0] pack_status(prot_t p, logic lat);
        logic [SR_W-1:0] s;
        s           = '0;
        s[BIT_LOCK] = p.lock;
        s[BIT_BPH]  = p.blk[1];
        s[BIT_BPL]  = p.blk[0];
        s[BIT_LAT]  = lat;
        return s;
    endfunction

    function automatic prot_t unpack_prot(logic [SR_W-1:0] d);
        prot_t p;
        p.lock = d[BIT_LOCK];
        p.blk  = {d[BIT_BPH], d[BIT_BPL]};
        return p;
    endfunction

endpackage

// File: rtl/wp_enable_fsm.sv
module wp_enable_fsm
    import wp_status_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic done_i,
    output logic open_o
);

    en_state_e state_q, state_d;
    logic      closing;

    assign closing = clr_i | done_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= EN_CLOSED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EN_CLOSED: if (set_i && !closing) state_d = EN_OPEN;   // OPEN_ON_SET
            EN_OPEN:   if (closing)           state_d = EN_CLOSED; // CLOSE_ON_CLEAR
            default:                          state_d = EN_CLOSED;
        endcase
    end

    always_comb begin
        unique case (state_q)
            EN_OPEN: open_o = 1'b1;
            default: open_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/wp_prot_regs.sv
module wp_prot_regs
    import wp_status_pkg::*;
#(
    parameter prot_t RST_VAL = '0
)(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load_i,
    input  prot_t din_i,
    output prot_t q_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      q_o <= RST_VAL;
        else if (load_i) q_o <= din_i;
    end

endmodule

// File: rtl/wp_range_decode.sv
module wp_range_decode #(
    parameter int ADDR_W = 13
)(
    input  logic [1:0]        blk_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              hit_o
);

    localparam logic [ADDR_W-1:0] HALF_BASE = ADDR_W'(1) << (ADDR_W - 1);
    localparam logic [ADDR_W-1:0] QTR_BASE  = ADDR_W'(3) << (ADDR_W - 2);

    always_comb begin
        unique case (blk_i)
            2'b00:   hit_o = 1'b0;
            2'b01:   hit_o = (addr_i >= QTR_BASE);
            2'b10:   hit_o = (addr_i >= HALF_BASE);
            default: hit_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/wp_status_unit.sv
module wp_status_unit
    import wp_status_pkg::*;
#(
    parameter int         ADDR_W   = 13,
    parameter logic [2:0] RST_PROT = 3'b000
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_set_en,
    input  logic              cmd_clr_en,
    input  logic              sr_wr_valid,
    input  logic [SR_W-1:0]   sr_wr_data,
    input  logic              wr_done,
    input  logic              hw_wp_n,
    input  logic [ADDR_W-1:0] cand_addr,
    output logic [SR_W-1:0]   status_byte,
    output logic              sr_wr_permit,
    output logic              mem_wr_permit
);

    logic  latch_open;
    logic  prot_hit;
    logic  sr_load;
    prot_t prot_q;

    wp_enable_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (cmd_set_en),
        .clr_i  (cmd_clr_en),
        .done_i (wr_done),
        .open_o (latch_open)
    );

    assign sr_wr_permit = latch_open & ~(prot_q.lock & ~hw_wp_n);
    assign sr_load      = sr_wr_valid & sr_wr_permit;

    wp_prot_regs #(.RST_VAL(prot_t'(RST_PROT))) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (sr_load),
        .din_i  (unpack_prot(sr_wr_data)),
        .q_o    (prot_q)
    );

    wp_range_decode #(.ADDR_W(ADDR_W)) u_dec (
        .blk_i  (prot_q.blk),
        .addr_i (cand_addr),
        .hit_o  (prot_hit)
    );

    assign mem_wr_permit = latch_open & ~prot_hit;
    assign status_byte   = pack_status(prot_q, latch_open);

endmodule

// File: rtl/wp_status_checker.sv
module wp_status_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_set_en,
    input logic       cmd_clr_en,
    input logic       wr_done,
    input logic       sr_wr_valid,
    input logic       hw_wp_n,
    input logic [7:0] status_byte,
    input logic       sr_wr_permit,
    input logic       mem_wr_permit
);

    a_r1_fixed_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (status_byte[6:4] == 3'b000) && (status_byte[0] == 1'b0));

    a_r2_latch_opens: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_set_en && !cmd_clr_en && !wr_done) |=> status_byte[1]);

    a_r2_latch_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_clr_en || wr_done) |=> !status_byte[1]);

    a_r3_no_load_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        !(sr_wr_valid && sr_wr_permit) |=> $stable({status_byte[7], status_byte[3:2]}));

    a_r4_full_block: assert property (@(posedge clk) disable iff (!rst_n)
        (status_byte[3:2] == 2'b11) |-> !mem_wr_permit);

    a_r5_mem_needs_latch: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_permit |-> status_byte[1]);

    a_r6_pin_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (status_byte[7] && !hw_wp_n) |-> !sr_wr_permit);

    a_r6_sr_needs_latch: assert property (@(posedge clk) disable iff (!rst_n)
        sr_wr_permit |-> status_byte[1]);

endmodule

bind wp_status_unit wp_status_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_set_en    (cmd_set_en),
    .cmd_clr_en    (cmd_clr_en),
    .wr_done       (wr_done),
    .sr_wr_valid   (sr_wr_valid),
    .hw_wp_n       (hw_wp_n),
    .status_byte   (status_byte),
    .sr_wr_permit  (sr_wr_permit),
    .mem_wr_permit (mem_wr_permit)
);

// File: tb/tb_wp_status_unit.sv
module tb_wp_status_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_set_en = 1'b0, cmd_clr_en = 1'b0, sr_wr_valid = 1'b0, wr_done = 1'b0;
    logic [7:0]  sr_wr_data = 8'h00;
    logic        hw_wp_n = 1'b1;
    logic [12:0] cand_addr = 13'h0;
    logic [7:0]  status_byte;
    logic        sr_wr_permit, mem_wr_permit;

    int checks = 0;
    int fails  = 0;
    int m_lat = 0, m_lock = 0, m_bp = 0;

    always #5 clk = ~clk;

    wp_status_unit dut (
        .clk(clk), .rst_n(rst_n), .cmd_set_en(cmd_set_en), .cmd_clr_en(cmd_clr_en),
        .sr_wr_valid(sr_wr_valid), .sr_wr_data(sr_wr_data), .wr_done(wr_done),
        .hw_wp_n(hw_wp_n), .cand_addr(cand_addr), .status_byte(status_byte),
        .sr_wr_permit(sr_wr_permit), .mem_wr_permit(mem_wr_permit)
    );

    function automatic int in_fence(int bp, int a);
        if (bp == 3) return 1;
        if (bp == 2) return (a >= 'h1000) ? 1 : 0;
        if (bp == 1) return (a >= 'h1800) ? 1 : 0;
        return 0;
    endfunction

    function automatic int exp_sr_ok();
        return (m_lat == 1 && !(m_lock == 1 && hw_wp_n == 1'b0)) ? 1 : 0;
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        int exp_status;
        exp_status = m_lock * 128 + m_bp * 4 + m_lat * 2;
        check("R1 status_byte", int'(status_byte), exp_status);
        check("R5 mem_wr_permit", int'(mem_wr_permit),
              (m_lat == 1 && in_fence(m_bp, int'(cand_addr)) == 0) ? 1 : 0);
        check("R6 sr_wr_permit", int'(sr_wr_permit), exp_sr_ok());
    endtask

    task automatic cyc(bit set, bit clr, bit srv, logic [7:0] d, bit done, bit wpn, int addr);
        int ok;
        @(negedge clk);
        cmd_set_en = set; cmd_clr_en = clr; sr_wr_valid = srv; sr_wr_data = d;
        wr_done = done; hw_wp_n = wpn; cand_addr = 13'(addr);
        #1 compare_all();
        ok = exp_sr_ok();
        @(posedge clk);
        #1;
        if (srv && ok == 1) begin
            m_lock = int'(d[7]);
            m_bp   = int'(d[3:2]);
        end
        if (clr || done) m_lat = 0;
        else if (set)    m_lat = 1;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R8: defaults after reset, latch closed
        #1 check("R8 reset status", int'(status_byte), 0);
        check("R2 latch after reset", int'(status_byte[1]), 0);
        // R5: closed latch denies every address
        cyc(0,0,0,8'h00,0,1,'h0000);
        cyc(0,0,0,8'h00,0,1,'h1FFF);
        // R2: open latch
        cyc(1,0,0,8'h00,0,1,'h0000);
        check("R2 latch open", int'(status_byte[1]), 1);
        cyc(0,0,0,8'h00,0,1,'h1FFF);
        // R3: load all ones, only lock and block bits take effect
        cyc(0,0,1,8'hFF,0,1,'h0000);
        check("R3 masked load", int'(status_byte), 'h8E);
        // R4: code 11 fences everything; R9 permits follow next cycle
        cyc(0,0,0,8'h00,0,1,'h0000);
        cyc(0,0,0,8'h00,0,1,'h0FFF);
        // R6: lock with pin low blocks a load
        cyc(0,0,1,8'h00,0,0,'h0000);
        check("R3 blocked load", int'(status_byte), 'h8E);
        // R2: end of write closes the latch
        cyc(0,0,0,8'h00,1,1,'h0000);
        check("R2 end-of-write close", int'(status_byte[1]), 0);
        // R4: quarter fence via code 01
        cyc(1,0,0,8'h00,0,1,'h0000);
        cyc(0,0,1,8'h04,0,1,'h0000);
        cyc(1,0,0,8'h00,0,1,'h17FF);
        check("R4 below quarter", int'(mem_wr_permit), 1);
        cyc(0,0,0,8'h00,0,1,'h1800);
        cyc(0,0,0,8'h00,0,0,'h1800);
        // R7: pin low does not change array permit
        cyc(0,0,0,8'h00,0,0,'h0123);
        check("R7 pin ignored for array", int'(mem_wr_permit), 1);
        // R6: lock flag 0 ignores pin
        check("R6 pin ignored", int'(sr_wr_permit), 1);
        // R4: half fence via code 10
        cyc(0,0,1,8'h08,0,0,'h0000);
        cyc(0,0,0,8'h00,0,1,'h0FFF);
        cyc(0,0,0,8'h00,0,1,'h1000);
        check("R4 half boundary", int'(mem_wr_permit), 0);
        // R2: set and close in same cycle -> closed
        cyc(1,1,0,8'h00,0,1,'h0000);
        check("R2 clear wins", int'(status_byte[1]), 0);
        cyc(1,0,0,8'h00,1,1,'h0000);
        check("R2 done wins", int'(status_byte[1]), 0);
        // R9: randomized traffic compared every cycle
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r;
            r = $urandom;
            cyc(r[0], r[1] & r[2] & r[3], r[4], r[12:5], r[13] & r[14], r[15] | r[16],
                int'(r[29:17]));
        end
        cyc(0,0,0,8'h00,0,1,'h0000);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule